// File: doc/BRIEF.md
# Scanline-Stepped Interrupt Timer

This block is a 16-bit interrupt timer on the cartridge side of a CPU bus. Software programs it through four write-only register addresses: one stops counting, one starts it, and two load the low and high bytes of the count. While it runs, each scanline pulse takes a fixed step of 123 off the count. When a step leaves the count at zero or below, the block raises a level interrupt request. In the same cycle it stops itself and sets the count to all ones.

The interrupt line is a latch. It stays high until software writes to any of the four timer addresses, and reset also clears it. A timer write that arrives in the same cycle as a scanline pulse wins, and that pulse is dropped. Writes to any other address have no effect.

Top module: `scanline_irq_timer`

## Requirements
- R1: After reset the interrupt output is low, counting is stopped and the count is 0, so starting the timer straight after reset raises the interrupt on the first scanline pulse.
- R2: A write to 0xF001 starts counting and a write to 0xF000 stops it. While stopped, scanline pulses leave the count unchanged.
- R3: A write to 0xF002 replaces the low byte (bits 7:0) of the count with the write data. A write to 0xF003 replaces the high byte (bits 15:8). In both cases the other byte is kept.
- R4: While counting, each scanline pulse subtracts 123 from the count. For a loaded count N, the interrupt rises on pulse number max(1, ceil(N/123)).
- R5: When a step leaves the count at zero or below, three things happen on the clock edge that samples that pulse: the interrupt goes high, counting stops, and the count becomes 0xFFFF. Restarting with no new load therefore takes 533 pulses.
- R6: Once high, the interrupt stays high until a write to any of 0xF000 to 0xF003, which clears it on that write's clock edge.
- R7: If a timer register write and a scanline pulse arrive in the same cycle, the write takes effect and the pulse is discarded.
- R8: Writes to addresses other than 0xF000 to 0xF003 change neither the count, the run state nor the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| line_pulse | input | 1 | Scanline pulse, one cycle per scanline |
| irq | output | 1 | Active-high level interrupt request |

## Verification
The assertions assume that each write and each scanline pulse is a single-cycle strobe sampled on one edge. They also assume that the address and data are valid whenever the strobe is high. They make no assumption about the spacing of events, so back-to-back and coincident events are legal. The stimulus drives every strobe for exactly one cycle, changes inputs only on the falling edge, and deliberately places timer writes and pulses in the same cycle to exercise the priority rule. It also writes to addresses that share low bits with the timer registers. It sweeps the loaded count across hundreds of consecutive values and predicts each firing pulse from the ceiling division alone.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int CNT_W  = 16;
  localparam int BYTE_W = 8;
  localparam int LANES  = CNT_W / BYTE_W;
  localparam int SLOTS  = 2 + LANES;

  typedef struct packed {
    logic             stop;
    logic             run;
    logic [LANES-1:0] lane_we;
    logic             ack;
  } tmr_ctl_t;
endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/tmr_wr_decode.sv
module tmr_wr_decode
  import timer_pkg::*;
#(
  parameter int              ADDR_W = 16,
  parameter logic [15:0]     BASE   = 16'hF000
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output tmr_ctl_t          ctl
);
  logic [SLOTS-1:0] hit;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    localparam logic [ADDR_W-1:0] SLOT_ADDR = ADDR_W'(BASE) + ADDR_W'(s);
    assign hit[s] = wr_en && (wr_addr == SLOT_ADDR);
  end

  always_comb begin
    ctl.stop    = hit[0];
    ctl.run     = hit[1];
    ctl.lane_we = hit[2 +: LANES];
    ctl.ack     = |hit;
  end
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
  import timer_pkg::*;
#(
  parameter int STEP = 123
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tmr_ctl_t          ctl,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              line_pulse,
  output logic              fire
);
  localparam logic [CNT_W-1:0] RELOAD = '1;
  localparam logic [CNT_W:0]   STEP_X = (CNT_W+1)'(STEP);

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_loaded;
  logic             en_q, en_d;
  logic             cnt_ce, en_ce;
  logic             step_ok;
  logic [CNT_W:0]   diff;
  logic             under;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign cnt_loaded[l*BYTE_W +: BYTE_W] =
      ctl.lane_we[l] ? wr_data : cnt_q[l*BYTE_W +: BYTE_W];
  end

  assign step_ok = en_q && line_pulse && !ctl.ack;
  assign diff    = {1'b0, cnt_q} - STEP_X;
  assign under   = diff[CNT_W] || (diff == '0);

  always_comb begin
    cnt_d = cnt_loaded;
    en_d  = en_q;
    fire  = 1'b0;
    if (ctl.stop)     en_d = 1'b0;
    else if (ctl.run) en_d = 1'b1;
    if (step_ok) begin
      if (under) begin
        fire  = 1'b1;
        en_d  = 1'b0;
        cnt_d = RELOAD;
      end else begin
        cnt_d = diff[CNT_W-1:0];
      end
    end
  end

  assign cnt_ce = ctl.ack || step_ok;
  assign en_ce  = ctl.stop || ctl.run || fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else begin
      if (cnt_ce) cnt_q <= cnt_d;
      if (en_ce)  en_q  <= en_d;
    end
  end

  // R2
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !ctl.ack) |=> $stable(cnt_q));

  // R4
  step_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && line_pulse && !ctl.ack && cnt_q > CNT_W'(STEP))
      |=> cnt_q == $past(cnt_q) - CNT_W'(STEP));

  // R5
  fire_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (cnt_q == RELOAD) && !en_q);

  for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
    // R3
    lane_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.lane_we[l] |=> cnt_q[l*BYTE_W +: BYTE_W] == $past(wr_data));
  end

  // R7
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.ack && line_pulse && !(|ctl.lane_we)) |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_irq_latch.sv
module tmr_irq_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic ack,
  output logic irq_q
);
  logic irq_d, irq_ce;

  assign irq_ce = fire || ack;

  always_comb begin
    if (ack) irq_d = 1'b0;
    else     irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      irq_q <= 1'b0;
    else if (irq_ce) irq_q <= irq_d;
  end

  // R6
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !ack) |=> irq_q);

  // R6
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !irq_q);

  // R5
  fire_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> irq_q);
endmodule

// File: rtl/scanline_irq_timer.sv
module scanline_irq_timer
  import timer_pkg::*;
#(
  parameter int          STEP = 123,
  parameter logic [15:0] BASE = 16'hF000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wr_addr,
  input  logic [7:0]  wr_data,
  input  logic        line_pulse,
  output logic        irq
);
  logic     rst_n_sync;
  tmr_ctl_t ctl;
  logic     fire;

  tmr_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_sync)
  );

  tmr_wr_decode #(.ADDR_W(16), .BASE(BASE)) u_dec (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .ctl     (ctl)
  );

  tmr_count_core #(.STEP(STEP)) u_core (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .ctl        (ctl),
    .wr_data    (wr_data),
    .line_pulse (line_pulse),
    .fire       (fire)
  );

  tmr_irq_latch u_irq (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .fire  (fire),
    .ack   (ctl.ack),
    .irq_q (irq)
  );

  // R8
  foreign_write_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (wr_en && (wr_addr[15:2] != BASE[15:2]) && !line_pulse && !fire) |=> $stable(irq));
endmodule

// File: tb/scanline_irq_timer_tb_top.sv
module scanline_irq_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [15:0] wr_addr;
  logic [7:0]  wr_data;
  logic        line_pulse;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  scanline_irq_timer dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .line_pulse(line_pulse), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse();
    line_pulse = 1'b1;
    @(negedge clk);
    line_pulse = 1'b0;
  endtask

  task automatic write_with_pulse(input logic [15:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d; line_pulse = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; line_pulse = 1'b0;
  endtask

  task automatic load(input int n);
    do_write(16'hF003, 8'((n >> 8) & 255));
    do_write(16'hF002, 8'(n & 255));
  endtask

  task automatic pulses_to_fire(input int cap, output int n);
    n = 0;
    while (n < cap && !irq) begin
      pulse();
      n++;
    end
  endtask

  function automatic int exp_pulses(input int n);
    if (n == 0) return 1;
    return (n + 122) / 123;
  endfunction

  task automatic apply_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; line_pulse = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check(irq == 1'b0, "R1 irq in reset", irq, 0);
    apply_reset();
    check(irq == 1'b0, "R1 irq after reset", irq, 0);

    // R1: count 0 after reset, fires on first pulse
    do_write(16'hF001, 8'h00);
    pulse();
    check(irq == 1'b1, "R1 zero count fires first pulse", irq, 1);
    do_write(16'hF000, 8'h00);
    check(irq == 1'b0, "R6 stop write acks", irq, 0);

    // R4: sweep of loaded counts
    for (int v = 0; v <= 700; v++) begin
      load(v);
      do_write(16'hF001, 8'h00);
      pulses_to_fire(600, n);
      check(n == exp_pulses(v), "R4 pulses to fire", n, exp_pulses(v));
      do_write(16'hF000, 8'h00);
      check(irq == 1'b0, "R6 ack after sweep fire", irq, 0);
    end
    for (int v = 65000; v <= 65535; v += 107) begin
      load(v);
      do_write(16'hF001, 8'h00);
      pulses_to_fire(600, n);
      check(n == exp_pulses(v), "R4 large count", n, exp_pulses(v));
      do_write(16'hF000, 8'h00);
    end

    // R3: byte writes keep the other byte
    load(16'h0210);
    do_write(16'hF001, 8'h00);
    pulses_to_fire(600, n);
    check(n == 5, "R3 both bytes 0x0210", n, 5);
    do_write(16'hF002, 8'h05);
    do_write(16'hF001, 8'h00);
    pulses_to_fire(600, n);
    check(n == 531, "R3 low byte keeps high 0xFF05", n, 531);
    do_write(16'hF003, 8'h01);
    do_write(16'hF001, 8'h00);
    pulses_to_fire(600, n);
    check(n == 5, "R3 high byte keeps low 0x01FF", n, 5);
    do_write(16'hF000, 8'h00);

    // R5: auto stop and reload
    load(10);
    do_write(16'hF001, 8'h00);
    pulse();
    check(irq == 1'b1, "R5 irq on firing pulse", irq, 1);
    do_write(16'hF003, 8'h00);
    check(irq == 1'b0, "R6 high byte write acks", irq, 0);
    repeat (5) pulse();
    check(irq == 1'b0, "R5 stopped after fire", irq, 0);
    do_write(16'hF001, 8'h00);
    pulses_to_fire(600, n);
    check(n == 3, "R5 count 0x00FF after fire", n, 3);
    repeat (5) pulse();
    check(irq == 1'b1, "R6 irq held through pulses", irq, 1);
    do_write(16'hF001, 8'h00);
    check(irq == 1'b0, "R6 start write acks", irq, 0);
    pulses_to_fire(600, n);
    check(n == 533, "R5 reload 0xFFFF", n, 533);
    do_write(16'hF000, 8'h00);

    // R2: stop holds the count
    load(512);
    do_write(16'hF001, 8'h00);
    repeat (2) pulse();
    check(irq == 1'b0, "R2 running not yet fired", irq, 0);
    do_write(16'hF000, 8'h00);
    repeat (10) pulse();
    check(irq == 1'b0, "R2 stopped no fire", irq, 0);
    do_write(16'hF001, 8'h00);
    pulses_to_fire(600, n);
    check(n == 3, "R2 resume remaining count", n, 3);

    // R6 and R8: foreign writes do not ack
    do_write(16'hE000, 8'h00);
    do_write(16'hF004, 8'h00);
    do_write(16'h7002, 8'h00);
    do_write(16'hF00F, 8'h01);
    check(irq == 1'b1, "R8 foreign writes keep irq", irq, 1);
    do_write(16'hF002, 8'h00);
    check(irq == 1'b0, "R6 low byte write acks", irq, 0);
    load(256);
    do_write(16'hF001, 8'h00);
    do_write(16'hE002, 8'h00);
    do_write(16'h7003, 8'h00);
    do_write(16'hF006, 8'h00);
    do_write(16'h0000, 8'h00);
    pulses_to_fire(600, n);
    check(n == 3, "R8 foreign writes keep count", n, 3);
    do_write(16'hF000, 8'h00);

    // R7: write beats coincident pulse
    load(246);
    do_write(16'hF001, 8'h00);
    repeat (3) write_with_pulse(16'hF001, 8'h00);
    pulses_to_fire(600, n);
    check(n == 2, "R7 pulses dropped on write", n, 2);
    do_write(16'hF003, 8'h00);
    do_write(16'hF001, 8'h00);
    write_with_pulse(16'hF002, 8'h7B);
    check(irq == 1'b0, "R7 no fire on write cycle", irq, 0);
    pulses_to_fire(600, n);
    check(n == 1, "R7 load wins over pulse", n, 1);

    // R1: reset mid-run clears irq and count
    load(500);
    check(irq == 1'b0, "R6 ack by load", irq, 0);
    do_write(16'hF001, 8'h00);
    repeat (4) pulse();
    rst_n = 1'b0;
    @(negedge clk);
    check(irq == 1'b0, "R1 irq low in reset", irq, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    repeat (3) pulse();
    check(irq == 1'b0, "R1 stopped after reset", irq, 0);
    do_write(16'hF001, 8'h00);
    pulse();
    check(irq == 1'b1, "R1 count zero after reset", irq, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule